// File: doc/BRIEF.md
# Buffered Compare/Capture Timer Channel

This block is one 16-bit timer channel. A counter advances on each enabled count tick and wraps from all ones to zero. Two general registers watch it. Each one is set up on its own either to compare against the counter or to capture the counter when its capture input shows a selected edge. A compare match can drive a channel output pin. Each general register has a partner buffer register. In compare mode the buffer preloads the next compare value. In capture mode the buffer keeps the previous captured value.

A simple register bus gives word or byte access to the counter, the general and buffer registers, a control register, a mode register and a flag register. Each general register owns a flag. A flag is set by a match or a capture, and software clears it by a read-then-write-zero handshake. Each flag drives an interrupt request through its own enable bit.

Each flag is held by a three-state machine. The states are FLG_IDLE (flag clear), FLG_SET (flag set, not yet read) and FLG_ARMED (flag set and seen by a read of the flag register). The transitions are:
- FLG_IDLE to FLG_SET on a match or capture event.
- FLG_SET to FLG_ARMED on a read of the flag register with no event in the same cycle.
- FLG_ARMED to FLG_SET on a new event.
- FLG_ARMED to FLG_IDLE on a write of 0 to the flag's bit.

Every other case holds the state.

Top module: `tmr_chan`

## Requirements
- R1: After reset the counter is 0x0000, both general registers and both buffer registers read 0xFFFF, control, mode and flags read 0, and both output pins and both interrupt requests are 0.
- R2: The counter register is at address 0. It increments by one on each cycle with `cnt_tick` high and wraps from 0xFFFF to 0x0000. A CPU write to the counter in the same cycle as a tick wins over the increment.
- R3: In capture mode (mode bit 2 = 1), a selected edge on `cap_in[n]` passes through a two-flop synchronizer and an edge detector. It loads the counter value into general register n on the third rising clock edge after the input changes, and it sets flag n in that same edge.
- R4: Mode bits [1:0] of a capture register pick the edge: 0 = rising, 1 = falling, 2 or 3 = both. An edge that is not selected changes nothing.
- R5: In compare mode (mode bit 2 = 0), a match occurs when a tick arrives while the counter equals general register n. On the next edge flag n is set and `cmp_out[n]` follows mode bits [1:0]: 0 = unchanged, 1 = low, 2 = high, 3 = toggle.
- R6: With buffering on for register n (control bit 1+n) in compare mode, a match copies buffer register n into general register n.
- R7: With buffering on in capture mode, a capture moves the old general register value into buffer register n while the counter goes into general register n.
- R8: Registers are addressed as follows: 0 counter, 1 general A, 2 general B, 3 buffer A, 4 buffer B, 5 control, 6 mode, 7 flags. Counter, general and buffer registers take word writes and single-byte writes (`bus_be[1]` = bits 15:8, `bus_be[0]` = bits 7:0). Control and mode are written by the low-byte lane. Mode holds register A in bits [2:0] and register B in bits [6:4].
- R9: With control bit 0 set, a match of register A clears the counter to 0 instead of incrementing it.
- R10: A capture in the same cycle as a CPU write to that general register wins over the write. Writes at other times load the register.
- R11: Flag n (flag register bit n) clears only on a write of 0 to bit n after the flag was read as 1. Writing 0 before such a read, or writing 1, leaves it set.
- R12: `irq[n]` is flag n ANDed with control bit 3+n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | Count enable, one increment per high cycle |
| cap_in | input | 2 | Capture inputs, asynchronous, one per general register |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (used by the flag handshake) |
| bus_addr | input | 3 | Register address |
| bus_be | input | 2 | Byte lane enables for writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| cmp_out | output | 2 | Compare output pins |
| irq | output | 2 | Interrupt requests |

## Verification
Register writes, counter ticks, compare-match pin, flag and reload effects all appear after exactly one rising edge. The bench therefore drives stimulus on a falling edge and checks on the following falling edge. Capture results need three rising edges: two for the synchronizer and one for the load. The bench confirms that the register still holds its old value after two edges and holds the new value after the third. To hit the capture-versus-write priority, the bench places its bus write in the window before that third edge. Unselected edges are checked after four edges, so that a late capture would still be seen.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        FLG_IDLE  = 2'd0,
        FLG_SET   = 2'd1,
        FLG_ARMED = 2'd2
    } flg_state_t;

    localparam logic [1:0] ACT_NONE   = 2'd0;
    localparam logic [1:0] ACT_LOW    = 2'd1;
    localparam logic [1:0] ACT_HIGH   = 2'd2;
    localparam logic [1:0] ACT_TOGGLE = 2'd3;

    localparam logic [1:0] EDGE_RISE  = 2'd0;
    localparam logic [1:0] EDGE_FALL  = 2'd1;

endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det #(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       din,
    input  logic [1:0] sel,
    output logic       evt
);
    import tmr_pkg::*;

    logic [STAGES-1:0] sync_q;
    logic              last_q;
    logic              rise;
    logic              fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~last_q;
    assign fall = ~sync_q[STAGES-1] & last_q;

    always_comb begin
        if (sel[1])                evt = rise | fall;
        else if (sel == EDGE_FALL) evt = fall;
        else                       evt = rise;
    end

endmodule

// File: rtl/tmr_flag_fsm.sv
module tmr_flag_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic rd_seen,
    input  logic wr_zero,
    output logic flag
);
    import tmr_pkg::*;

    flg_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE:  if (set_evt) state_d = FLG_SET;
            FLG_SET:   if (rd_seen && !set_evt) state_d = FLG_ARMED;
            FLG_ARMED: begin
                if (set_evt)      state_d = FLG_SET;
                else if (wr_zero) state_d = FLG_IDLE;
            end
            default:   state_d = FLG_IDLE;
        endcase
    end

    always_comb begin
        flag = (state_q != FLG_IDLE);
    end

    a_r5_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);

    a_r11_clear_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> ($past(state_q) == FLG_ARMED && $past(wr_zero)));

endmodule

// File: rtl/tmr_gr_unit.sv
module tmr_gr_unit #(
    parameter int W      = 16,
    parameter int STAGES = 2,
    localparam int BE_W  = W / 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      mode,
    input  logic            buf_en,
    input  logic [W-1:0]    cnt,
    input  logic            cnt_tick,
    input  logic            cap_in,
    input  logic            wr_gr,
    input  logic            wr_br,
    input  logic [BE_W-1:0] be,
    input  logic [W-1:0]    wdata,
    output logic [W-1:0]    gr,
    output logic [W-1:0]    br,
    output logic            match,
    output logic            cap_evt,
    output logic            pin
);
    import tmr_pkg::*;

    logic         cap_mode;
    logic         raw_evt;
    logic [W-1:0] gr_q, br_q, gr_wval, br_wval;
    logic         pin_q;

    assign cap_mode = mode[2];

    tmr_edge_det #(.STAGES(STAGES)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cap_in),
        .sel   (mode[1:0]),
        .evt   (raw_evt)
    );

    assign cap_evt = cap_mode & raw_evt;
    assign match   = ~cap_mode & cnt_tick & (cnt == gr_q);

    always_comb begin
        gr_wval = gr_q;
        br_wval = br_q;
        for (int b = 0; b < BE_W; b++) begin
            if (be[b]) begin
                gr_wval[b*8 +: 8] = wdata[b*8 +: 8];
                br_wval[b*8 +: 8] = wdata[b*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                gr_q <= '1;
        else if (cap_evt)          gr_q <= cnt;
        else if (match && buf_en)  gr_q <= br_q;
        else if (wr_gr)            gr_q <= gr_wval;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 br_q <= '1;
        else if (cap_evt && buf_en) br_q <= gr_q;
        else if (wr_br)             br_q <= br_wval;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
        end else if (match) begin
            unique case (mode[1:0])
                ACT_NONE:   pin_q <= pin_q;
                ACT_LOW:    pin_q <= 1'b0;
                ACT_HIGH:   pin_q <= 1'b1;
                ACT_TOGGLE: pin_q <= ~pin_q;
            endcase
        end
    end

    assign gr  = gr_q;
    assign br  = br_q;
    assign pin = pin_q;

    a_r3_capture_loads: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> gr_q == $past(cnt));

    a_r7_capture_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt && buf_en) |=> br_q == $past(gr_q));

    a_r6_compare_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (match && buf_en) |=> gr_q == $past(br_q));

    a_r5_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (match && mode[1:0] == ACT_TOGGLE) |=> pin_q != $past(pin_q));

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
    parameter int  CNT_W       = 16,
    parameter int  NUM_GR      = 2,
    parameter int  SYNC_STAGES = 2,
    localparam int ADDR_W      = $clog2(4 + 2 * NUM_GR),
    localparam int BE_W        = CNT_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_tick,
    input  logic [NUM_GR-1:0] cap_in,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NUM_GR-1:0] cmp_out,
    output logic [NUM_GR-1:0] irq
);
    localparam int CTRL_W = 1 + 2 * NUM_GR;
    localparam int A_CNT  = 0;
    localparam int A_CTRL = 1 + 2 * NUM_GR;
    localparam int A_MODE = 2 + 2 * NUM_GR;
    localparam int A_FLAG = 3 + 2 * NUM_GR;

    logic [CNT_W-1:0]  cnt_q, cnt_wval;
    logic [CTRL_W-1:0] ctrl_q;
    logic [2:0]        mode_q [NUM_GR];
    logic [CNT_W-1:0]  gr_val [NUM_GR];
    logic [CNT_W-1:0]  br_val [NUM_GR];
    logic [NUM_GR-1:0] match, cap_evt, flag;
    logic              wr_cnt;

    assign wr_cnt = bus_wr && (bus_addr == ADDR_W'(A_CNT));

    always_comb begin
        cnt_wval = cnt_q;
        for (int b = 0; b < BE_W; b++) begin
            if (bus_be[b]) cnt_wval[b*8 +: 8] = bus_wdata[b*8 +: 8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_cnt) begin
            cnt_q <= cnt_wval;
        end else if (cnt_tick) begin
            if (ctrl_q[0] && match[0]) cnt_q <= '0;
            else                       cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (bus_wr && bus_be[0] && bus_addr == ADDR_W'(A_CTRL)) begin
            ctrl_q <= bus_wdata[CTRL_W-1:0];
        end
    end

    for (genvar g = 0; g < NUM_GR; g++) begin : g_gr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mode_q[g] <= '0;
            end else if (bus_wr && bus_be[0] && bus_addr == ADDR_W'(A_MODE)) begin
                mode_q[g] <= bus_wdata[g*4 +: 3];
            end
        end

        tmr_gr_unit #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_gr (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode     (mode_q[g]),
            .buf_en   (ctrl_q[1+g]),
            .cnt      (cnt_q),
            .cnt_tick (cnt_tick),
            .cap_in   (cap_in[g]),
            .wr_gr    (bus_wr && bus_addr == ADDR_W'(1 + g)),
            .wr_br    (bus_wr && bus_addr == ADDR_W'(1 + NUM_GR + g)),
            .be       (bus_be),
            .wdata    (bus_wdata),
            .gr       (gr_val[g]),
            .br       (br_val[g]),
            .match    (match[g]),
            .cap_evt  (cap_evt[g]),
            .pin      (cmp_out[g])
        );

        tmr_flag_fsm u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_evt (match[g] | cap_evt[g]),
            .rd_seen (bus_rd && bus_addr == ADDR_W'(A_FLAG)),
            .wr_zero (bus_wr && bus_be[0] && bus_addr == ADDR_W'(A_FLAG) && !bus_wdata[g]),
            .flag    (flag[g])
        );

        assign irq[g] = flag[g] & ctrl_q[1+NUM_GR+g];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_CNT))  bus_rdata = cnt_q;
        if (bus_addr == ADDR_W'(A_CTRL)) bus_rdata[CTRL_W-1:0] = ctrl_q;
        if (bus_addr == ADDR_W'(A_FLAG)) bus_rdata[NUM_GR-1:0] = flag;
        for (int i = 0; i < NUM_GR; i++) begin
            if (bus_addr == ADDR_W'(1 + i))          bus_rdata = gr_val[i];
            if (bus_addr == ADDR_W'(1 + NUM_GR + i)) bus_rdata = br_val[i];
            if (bus_addr == ADDR_W'(A_MODE))         bus_rdata[i*4 +: 3] = mode_q[i];
        end
    end

    a_r2_wraps_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick && !wr_cnt && !(ctrl_q[0] && match[0]) && cnt_q == '1) |=> cnt_q == '0);

    a_r2_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cnt && bus_be == '1) |=> cnt_q == $past(bus_wdata));

    a_r9_clear_on_a: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick && !wr_cnt && ctrl_q[0] && match[0]) |=> cnt_q == '0);

endmodule

// File: tb/tmr_chan_test.sv
module tmr_chan_test;

    localparam logic [2:0] A_CNT = 3'd0, A_GA = 3'd1, A_GB = 3'd2, A_BA = 3'd3,
                           A_BB = 3'd4, A_CTRL = 3'd5, A_MODE = 3'd6, A_FLAG = 3'd7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_tick = 1'b0;
    logic [1:0]  cap_in = 2'b00;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [1:0]  bus_be = 2'b00;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic [1:0]  cmp_out;
    logic [1:0]  irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    tmr_chan uut (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .cap_in(cap_in),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_out(cmp_out), .irq(irq)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bwr(logic [2:0] a, logic [15:0] d, logic [1:0] be);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic run_ticks(int n);
        @(negedge clk);
        cnt_tick = 1'b1;
        repeat (n) @(negedge clk);
        cnt_tick = 1'b0;
    endtask

    task automatic clear_flags();
        logic [15:0] d;
        brd(A_FLAG, d);
        bwr(A_FLAG, 16'h0000, 2'b01);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        brd(A_CNT, d);  chk("R1 counter", d, 16'h0000);
        brd(A_GA, d);   chk("R1 general A", d, 16'hFFFF);
        brd(A_GB, d);   chk("R1 general B", d, 16'hFFFF);
        brd(A_BA, d);   chk("R1 buffer A", d, 16'hFFFF);
        brd(A_BB, d);   chk("R1 buffer B", d, 16'hFFFF);
        brd(A_MODE, d); chk("R1 mode", d, 16'h0000);
        brd(A_FLAG, d); chk("R1 flags", d, 16'h0000);
        chk("R1 pins", 16'(cmp_out), 16'h0000);
        chk("R1 irq", 16'(irq), 16'h0000);
    endtask

    task automatic t_bytes();
        logic [15:0] d;
        bwr(A_CNT, 16'h1234, 2'b11);
        bwr(A_CNT, 16'hAB00, 2'b10);
        brd(A_CNT, d); chk("R8 high byte write", d, 16'hAB34);
        bwr(A_CNT, 16'h00CD, 2'b01);
        brd(A_CNT, d); chk("R8 low byte write", d, 16'hABCD);
        bwr(A_GA, 16'h5A5A, 2'b01);
        brd(A_GA, d);  chk("R8 general low byte", d, 16'hFF5A);
        bwr(A_GA, 16'hFFFF, 2'b11);
    endtask

    task automatic t_counter();
        logic [15:0] d;
        bwr(A_CNT, 16'hFFFE, 2'b11);
        run_ticks(3);
        brd(A_CNT, d); chk("R2 wrap", d, 16'h0001);
        @(negedge clk);
        cnt_tick = 1'b1;
        bus_addr = A_CNT; bus_wdata = 16'h0100; bus_be = 2'b11; bus_wr = 1'b1;
        @(negedge clk);
        cnt_tick = 1'b0; bus_wr = 1'b0;
        brd(A_CNT, d); chk("R2 write beats tick", d, 16'h0100);
        run_ticks(2);
        brd(A_CNT, d); chk("R2 increment", d, 16'h0102);
    endtask

    task automatic t_compare();
        logic [15:0] d;
        clear_flags();
        brd(A_FLAG, d); chk("R11 flags cleared", d, 16'h0000);
        bwr(A_MODE, 16'h0023, 2'b01);
        bwr(A_GA, 16'h0005, 2'b11);
        bwr(A_GB, 16'h0005, 2'b11);
        bwr(A_CNT, 16'h0003, 2'b11);
        run_ticks(3);
        chk("R5 toggle and high", 16'(cmp_out), 16'h0003);
        brd(A_CNT, d);  chk("R5 counter after match", d, 16'h0006);
        brd(A_FLAG, d); chk("R5 flags set", d, 16'h0003);
        bwr(A_CTRL, 16'h0018, 2'b01);
        chk("R12 irq enabled", 16'(irq), 16'h0003);
        bwr(A_FLAG, 16'h0002, 2'b01);
        chk("R11 write 1 keeps B", 16'(irq), 16'h0002);
        bwr(A_FLAG, 16'h0000, 2'b01);
        chk("R11 write 0 after read", 16'(irq), 16'h0000);
        bwr(A_MODE, 16'h0013, 2'b01);
        bwr(A_CNT, 16'h0005, 2'b11);
        run_ticks(1);
        chk("R5 toggle back and low", 16'(cmp_out), 16'h0000);
        chk("R12 irq on match", 16'(irq), 16'h0003);
        bwr(A_FLAG, 16'h0000, 2'b01);
        chk("R11 write 0 without read", 16'(irq), 16'h0003);
        clear_flags();
        chk("R11 cleared after read", 16'(irq), 16'h0000);
        bwr(A_CTRL, 16'h0000, 2'b01);
        chk("R12 irq masked", 16'(irq), 16'h0000);
    endtask

    task automatic t_buffer_cmp();
        logic [15:0] d;
        bwr(A_MODE, 16'h0000, 2'b01);
        bwr(A_CTRL, 16'h0003, 2'b01);
        bwr(A_GA, 16'h0010, 2'b11);
        bwr(A_BA, 16'h0020, 2'b11);
        bwr(A_CNT, 16'h0010, 2'b11);
        run_ticks(1);
        brd(A_GA, d);  chk("R6 buffer reloads general", d, 16'h0020);
        brd(A_CNT, d); chk("R9 clear on A match", d, 16'h0000);
        bwr(A_CNT, 16'h0020, 2'b11);
        run_ticks(1);
        brd(A_CNT, d); chk("R9 clear again", d, 16'h0000);
        bwr(A_CTRL, 16'h0000, 2'b01);
    endtask

    task automatic t_capture();
        logic [15:0] d;
        bwr(A_MODE, 16'h0004, 2'b01);
        clear_flags();
        bwr(A_CNT, 16'h1111, 2'b11);
        @(negedge clk); cap_in[0] = 1'b1;
        @(negedge clk); @(negedge clk);
        peek(A_GA, d); chk("R3 not yet captured", d, 16'h0020);
        @(negedge clk);
        peek(A_GA, d); chk("R3 captured on third edge", d, 16'h1111);
        peek(A_FLAG, d); chk("R3 capture sets flag", d, 16'h0001);
        bwr(A_CNT, 16'h2222, 2'b11);
        @(negedge clk); cap_in[0] = 1'b0;
        repeat (4) @(negedge clk);
        peek(A_GA, d); chk("R4 falling ignored in rising mode", d, 16'h1111);
        bwr(A_MODE, 16'h0006, 2'b01);
        bwr(A_CNT, 16'h3333, 2'b11);
        @(negedge clk); cap_in[0] = 1'b1;
        repeat (4) @(negedge clk);
        peek(A_GA, d); chk("R4 both edges rising", d, 16'h3333);
        bwr(A_MODE, 16'h0005, 2'b01);
        bwr(A_CNT, 16'h4444, 2'b11);
        @(negedge clk); cap_in[0] = 1'b0;
        repeat (4) @(negedge clk);
        peek(A_GA, d); chk("R4 falling mode", d, 16'h4444);
        bwr(A_CNT, 16'h5151, 2'b11);
        @(negedge clk); cap_in[0] = 1'b1;
        repeat (4) @(negedge clk);
        peek(A_GA, d); chk("R4 rising ignored in falling mode", d, 16'h4444);
    endtask

    task automatic t_buf_capture();
        logic [15:0] d;
        bwr(A_MODE, 16'h0040, 2'b01);
        bwr(A_CTRL, 16'h0004, 2'b01);
        bwr(A_GB, 16'h0AAA, 2'b11);
        bwr(A_BB, 16'h0000, 2'b11);
        bwr(A_CNT, 16'h5555, 2'b11);
        @(negedge clk); cap_in[1] = 1'b1;
        repeat (4) @(negedge clk);
        peek(A_GB, d); chk("R7 new capture", d, 16'h5555);
        peek(A_BB, d); chk("R7 old value in buffer", d, 16'h0AAA);
        bwr(A_CNT, 16'h6565, 2'b11);
        @(negedge clk); cap_in[1] = 1'b0;
        repeat (4) @(negedge clk);
        @(negedge clk); cap_in[1] = 1'b1;
        repeat (4) @(negedge clk);
        peek(A_GB, d); chk("R7 second capture", d, 16'h6565);
        peek(A_BB, d); chk("R7 history shifts", d, 16'h5555);
        bwr(A_CTRL, 16'h0000, 2'b01);
    endtask

    task automatic t_cap_vs_write();
        logic [15:0] d;
        bwr(A_MODE, 16'h0004, 2'b01);
        @(negedge clk); cap_in[0] = 1'b0;
        repeat (4) @(negedge clk);
        bwr(A_CNT, 16'h7070, 2'b11);
        @(negedge clk); cap_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_addr = A_GA; bus_wdata = 16'h7777; bus_be = 2'b11; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        peek(A_GA, d); chk("R10 capture beats write", d, 16'h7070);
        bwr(A_GA, 16'h1234, 2'b11);
        peek(A_GA, d); chk("R10 plain write loads", d, 16'h1234);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bytes();
        t_counter();
        t_compare();
        t_buffer_cmp();
        t_capture();
        t_buf_capture();
        t_cap_vs_write();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule